// File: doc/BRIEF.md
# Binary and Packed-Decimal Accumulator Arithmetic Unit

This block is the arithmetic core of a small 8-bit accumulator datapath. It does add-with-carry and subtract-with-borrow on an accumulator byte and an operand byte. A mode input selects plain binary or packed two-digit decimal (BCD) arithmetic. It also does a compare that produces only flags, and rotates one place left or right through the carry. It returns a result byte and four flags: zero (Z), negative (N), carry (C) and overflow (V). The surrounding core keeps the registers and decodes instructions. This unit only takes a request and returns the outcome.

A request is presented together with a one-cycle `valid_in` strobe. A small controller has three states. `S_IDLE` waits. `S_EXEC` holds the captured request while the result is computed and registered. `S_DONE` presents the result with `valid_out` high for exactly one cycle. The transitions are:

- ACCEPT: `S_IDLE` to `S_EXEC` on `valid_in`.
- FINISH: `S_EXEC` to `S_DONE`, unconditionally.
- CHAIN: `S_DONE` to `S_EXEC` on `valid_in`.
- RETIRE: `S_DONE` to `S_IDLE` with no `valid_in`.

A strobe that arrives while the controller is in `S_EXEC` is dropped. The result and flag outputs keep their value until the next computation.

In decimal addition, the zero, negative and overflow flags come from intermediate values rather than from the corrected byte. Zero comes from the plain binary sum. Negative comes from the sum before the tens-digit fix-up. Overflow comes from a signed sum of the digit parts. Software that tests these flags after a decimal add sees that behaviour.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result, `valid_out`, `result` and all four flags are 0.
- R2: A `valid_in` seen on a rising edge in `S_IDLE` or `S_DONE` produces `valid_out` high for exactly one cycle, after the second rising edge from the accepting one. A `valid_in` seen in `S_EXEC` is ignored: it produces neither a result nor a pulse.
- R3: Op code 0 with `dec_mode`=0 (binary add): result = (A+B+Cin) mod 256. C = bit 8 of that sum. V = 1 when A and B have equal bit 7 and the result's bit 7 differs from A's. Z = (result==0). N = result bit 7.
- R4: Op code 1 with `dec_mode`=0 (binary subtract): result = (A-B-(1-Cin)) mod 256. C = 1 when no borrow occurs. V = bit 7 of (A^B)&(A^result). Z and N come from the result.
- R5: Op code 0 with `dec_mode`=1 (decimal add): the units digit sum A[3:0]+B[3:0]+Cin is corrected by +6 when it is 10 or more. A carry of 0x10 then moves into the tens. 0x60 is added when the tens intermediate is 0xA0 or more. C = 1 when the corrected value is 0x100 or more, and the result is its low byte.
- R6: In decimal add, Z is 1 when (A+B+Cin) mod 256 is 0. N is bit 7 of the intermediate before the 0x60 correction. V is 1 when signed(A&0xF0)+signed(B&0xF0)+(corrected units part) lies outside -128..127.
- R7: Op code 1 with `dec_mode`=1 (decimal subtract): a negative units difference A[3:0]-B[3:0]+Cin-1 is corrected by subtracting 6, keeping the nibble, then subtracting 0x10. A negative tens intermediate is corrected by subtracting 0x60. The result is the low byte. Z, N, C and V are the binary-subtract flags of R4.
- R8: Op code 2 (compare): result = A. Z = ((A-B) mod 256 == 0), N = bit 7 of (A-B) mod 256, C = (A >= B), V = 0. `carry_in` and `dec_mode` have no effect.
- R9: Op code 3 rotates left: result = {A[6:0],Cin}, C = A[7]. Op code 4 rotates right: result = {Cin,A[7:1]}, C = A[0]. Both set Z and N from the result and V = 0.
- R10: Op codes 5, 6 and 7 pass A through: result = A, Z and N from A, C = Cin, V = 0.
- R11: `result` and the flags change only on the edge that ends `S_EXEC`. They hold their values through `S_DONE`, `S_IDLE` and any input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe; the other request inputs are captured with it |
| op_sel | input | 3 | Operation code (0 add, 1 subtract, 2 compare, 3 rotate left, 4 rotate right, 5-7 pass) |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B |
| carry_in | input | 1 | Incoming carry flag |
| dec_mode | input | 1 | 1 selects packed-decimal add and subtract |
| valid_out | output | 1 | One-cycle pulse marking a new result |
| result | output | 8 | Result byte |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Binary add and subtract are tried with operand pairs chosen so that the carry and the overflow flag move independently. One pair gives overflow without carry, one gives carry without overflow, and one gives both. Decimal cases include a units-digit carry, a carry out of 99, and a borrow below zero. One non-decimal operand pair makes the binary sum zero while the corrected byte is not. Another case gives a zero corrected byte while Z stays clear. Together these separate flags taken from intermediates from flags taken from the final byte. Compare, rotate and pass codes are run with `carry_in` and `dec_mode` set both ways, which shows those inputs reach only the operations that use them. Directed sequences strobe twice in a row during `S_EXEC`, chain a request from `S_DONE`, and change inputs after a result, to test the pulse timing and the hold behaviour.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 3;
    localparam int SW  = DW + 3;   // signed width for decimal intermediates

    localparam logic [OPW-1:0] OP_ADD = 3'd0;
    localparam logic [OPW-1:0] OP_SUB = 3'd1;
    localparam logic [OPW-1:0] OP_CMP = 3'd2;
    localparam logic [OPW-1:0] OP_ROL = 3'd3;
    localparam logic [OPW-1:0] OP_ROR = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] res,
    output flags_t        flg
);

    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;

    // Subtraction is addition of the inverted operand; carry-in 1 means no borrow.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        res   = sum[DW-1:0];
        flg.c = sum[DW];
        flg.v = ~(a[DW-1] ^ b_eff[DW-1]) & (a[DW-1] ^ sum[DW-1]);
        flg.z = (sum[DW-1:0] == '0);
        flg.n = sum[DW-1];
    end

    // R3: two negative addends that overflow must always produce a carry
    always_comb begin
        if (!sub && a[DW-1] && b[DW-1] && flg.v)
            a_r3_neg_overflow_carries: assert (flg.c);
    end

endmodule

// File: rtl/bcd_alu_dec.sv
module bcd_alu_dec
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] add_res,
    output flags_t        add_flg,
    output logic [DW-1:0] sub_res
);

    logic [NW:0]          lo_sum;
    logic [NW:0]          lo_fix;
    logic [NW+3:0]        lo_tmp;
    logic [DW+1:0]        hi_raw;
    logic [DW+1:0]        hi_fix;
    logic [DW:0]          plain;
    logic signed [SW-1:0] sgn_sum;

    logic signed [NW+1:0] lo_dif;
    logic signed [NW+1:0] lo_dfix;
    logic signed [NW+1:0] lo_dtmp;
    logic signed [SW-1:0] hi_dif;
    logic signed [SW-1:0] hi_dfix;

    // Decimal add: units correction, tens correction, flags from intermediates (R5, R6)
    always_comb begin
        lo_sum = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        lo_tmp = {3'b000, lo_sum} + (NW+4)'(6);
        if (lo_sum >= (NW+1)'(10))
            lo_fix = {1'b1, lo_tmp[NW-1:0]};
        else
            lo_fix = lo_sum;
        hi_raw = {2'b00, a[DW-1:NW], {NW{1'b0}}}
               + {2'b00, b[DW-1:NW], {NW{1'b0}}}
               + {{(DW-NW+1){1'b0}}, lo_fix};
        if (hi_raw >= (DW+2)'(8'hA0))
            hi_fix = hi_raw + (DW+2)'(8'h60);
        else
            hi_fix = hi_raw;
        plain   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        sgn_sum = SW'($signed({a[DW-1:NW], {NW{1'b0}}}))
                + SW'($signed({b[DW-1:NW], {NW{1'b0}}}))
                + SW'($signed({1'b0, lo_fix}));
        add_res   = hi_fix[DW-1:0];
        add_flg.c = (hi_fix >= (DW+2)'(9'h100));
        add_flg.n = hi_raw[DW-1];
        add_flg.z = (plain[DW-1:0] == '0);
        add_flg.v = (sgn_sum > SW'(127)) || (sgn_sum < -SW'(128));
    end

    // Decimal subtract: borrow corrections on the units and tens parts (R7)
    always_comb begin
        lo_dif  = (NW+2)'($signed({2'b00, a[NW-1:0]}))
                - (NW+2)'($signed({2'b00, b[NW-1:0]}))
                + (NW+2)'($signed({1'b0, cin}))
                - (NW+2)'(1);
        lo_dtmp = lo_dif - (NW+2)'(6);
        if (lo_dif < 0)
            lo_dfix = {2'b11, lo_dtmp[NW-1:0]};
        else
            lo_dfix = lo_dif;
        hi_dif  = SW'($signed({3'b000, a[DW-1:NW], {NW{1'b0}}}))
                - SW'($signed({3'b000, b[DW-1:NW], {NW{1'b0}}}))
                + SW'(lo_dfix);
        if (hi_dif < 0)
            hi_dfix = hi_dif - SW'(8'h60);
        else
            hi_dfix = hi_dif;
        sub_res = hi_dfix[DW-1:0];
    end

    // R5: valid decimal operands always give valid decimal digits
    always_comb begin
        if (a[NW-1:0] <= NW'(9) && a[DW-1:NW] <= NW'(9) &&
            b[NW-1:0] <= NW'(9) && b[DW-1:NW] <= NW'(9)) begin
            a_r5_bcd_digits: assert (add_res[NW-1:0] <= NW'(9) && add_res[DW-1:NW] <= NW'(9) &&
                                     sub_res[NW-1:0] <= NW'(9) && sub_res[DW-1:NW] <= NW'(9));
        end
    end

endmodule

// File: rtl/bcd_alu_rot.sv
module bcd_alu_rot
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          right,
    output logic [DW-1:0] res,
    output flags_t        flg
);

    always_comb begin
        if (right) begin
            res   = {cin, a[DW-1:1]};
            flg.c = a[0];
        end else begin
            res   = {a[DW-2:0], cin};
            flg.c = a[DW-1];
        end
        flg.z = (res == '0);
        flg.n = res[DW-1];
        flg.v = 1'b0;
    end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_in,
    input  logic [2:0]     op_sel,
    input  logic [7:0]     acc_in,
    input  logic [7:0]     opnd_in,
    input  logic           carry_in,
    input  logic           dec_mode,
    output logic           valid_out,
    output logic [7:0]     result,
    output logic           flag_z,
    output logic           flag_n,
    output logic           flag_c,
    output logic           flag_v
);

    state_e         state_q;
    state_e         state_d;
    logic           accept;

    logic [OPW-1:0] op_q;
    logic [DW-1:0]  a_q;
    logic [DW-1:0]  b_q;
    logic           cin_q;
    logic           dec_q;

    logic [DW-1:0]  bin_res;
    flags_t         bin_flg;
    logic [DW-1:0]  dadd_res;
    flags_t         dadd_flg;
    logic [DW-1:0]  dsub_res;
    logic [DW-1:0]  rot_res;
    flags_t         rot_flg;
    logic           bin_sub;
    logic           bin_cin;

    logic [DW-1:0]  nxt_res;
    flags_t         nxt_flg;
    logic [DW-1:0]  res_q;
    flags_t         flg_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (valid_in) state_d = S_EXEC;       // ACCEPT
            S_EXEC:  state_d = S_DONE;                      // FINISH
            S_DONE:  state_d = valid_in ? S_EXEC : S_IDLE;  // CHAIN / RETIRE
            default: state_d = S_IDLE;
        endcase
    end

    assign accept = valid_in && (state_q != S_EXEC);

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            dec_q <= 1'b0;
        end else if (accept) begin
            op_q  <= op_sel;
            a_q   <= acc_in;
            b_q   <= opnd_in;
            cin_q <= carry_in;
            dec_q <= dec_mode;
        end
    end

    // ---------------- datapath units ----------------
    assign bin_sub = (op_q != OP_ADD);
    assign bin_cin = (op_q == OP_CMP) ? 1'b1 : cin_q;

    bcd_alu_bin u_bin (
        .a   (a_q),
        .b   (b_q),
        .cin (bin_cin),
        .sub (bin_sub),
        .res (bin_res),
        .flg (bin_flg)
    );

    bcd_alu_dec u_dec (
        .a       (a_q),
        .b       (b_q),
        .cin     (cin_q),
        .add_res (dadd_res),
        .add_flg (dadd_flg),
        .sub_res (dsub_res)
    );

    bcd_alu_rot u_rot (
        .a     (a_q),
        .cin   (cin_q),
        .right (op_q == OP_ROR),
        .res   (rot_res),
        .flg   (rot_flg)
    );

    // ---------------- operation select ----------------
    always_comb begin
        nxt_res = a_q;
        nxt_flg = '{z: (a_q == '0), n: a_q[DW-1], c: cin_q, v: 1'b0};
        case (op_q)
            OP_ADD: begin
                nxt_res = dec_q ? dadd_res : bin_res;
                nxt_flg = dec_q ? dadd_flg : bin_flg;
            end
            OP_SUB: begin
                nxt_res = dec_q ? dsub_res : bin_res;
                nxt_flg = bin_flg;
            end
            OP_CMP: begin
                nxt_res = a_q;
                nxt_flg = '{z: bin_flg.z, n: bin_flg.n, c: bin_flg.c, v: 1'b0};
            end
            OP_ROL, OP_ROR: begin
                nxt_res = rot_res;
                nxt_flg = rot_flg;
            end
            default: ;
        endcase
    end

    // ---------------- output registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (state_q == S_EXEC) begin
            res_q <= nxt_res;
            flg_q <= nxt_flg;
        end
    end

    assign valid_out = (state_q == S_DONE);
    assign result    = res_q;
    assign flag_z    = flg_q.z;
    assign flag_n    = flg_q.n;
    assign flag_c    = flg_q.c;
    assign flag_v    = flg_q.v;

    // ---------------- assertions ----------------
    // R2: the completion pulse never lasts more than one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out);

    // R2: every completion pulse traces back to a strobe two edges earlier
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $past(valid_in, 2));

    // R11: outputs move only on the edge that leaves S_EXEC
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_EXEC) |=> ($stable(result) && $stable(flag_c) && $stable(flag_v)));

    // R8: a compare never reports overflow
    a_r8_cmp_no_v: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && op_q == OP_CMP) |-> !flag_v);

endmodule

// File: tb/bcd_alu_bench.sv
module bcd_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;
    localparam int WD_LIMIT   = 5000;

    // {op[2:0], dec, cin, a[7:0], b[7:0], exp_res[7:0], exp_flags{z,n,c,v}}
    localparam logic [32:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b0, 8'h50, 8'h50, 8'hA0, 4'b0101},
        {3'd0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 4'b1010},
        {3'd0, 1'b0, 1'b1, 8'h80, 8'h80, 8'h01, 4'b0011},
        {3'd1, 1'b0, 1'b1, 8'h50, 8'hB0, 8'hA0, 4'b0101},
        {3'd1, 1'b0, 1'b0, 8'h40, 8'h40, 8'hFF, 4'b0100},
        {3'd1, 1'b0, 1'b1, 8'h40, 8'h10, 8'h30, 4'b0010},
        {3'd0, 1'b1, 1'b1, 8'h58, 8'h46, 8'h05, 4'b0111},
        {3'd0, 1'b1, 1'b0, 8'h99, 8'h01, 8'h00, 4'b0110},
        {3'd0, 1'b1, 1'b0, 8'h12, 8'h34, 8'h46, 4'b0000},
        {3'd0, 1'b1, 1'b0, 8'h50, 8'hB0, 8'h60, 4'b1010},
        {3'd1, 1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 4'b0100},
        {3'd1, 1'b1, 1'b1, 8'h50, 8'h25, 8'h25, 4'b0010},
        {3'd1, 1'b1, 1'b0, 8'h46, 8'h12, 8'h33, 4'b0010},
        {3'd2, 1'b0, 1'b0, 8'h30, 8'h30, 8'h30, 4'b1010},
        {3'd2, 1'b0, 1'b1, 8'h10, 8'h20, 8'h10, 4'b0100},
        {3'd2, 1'b1, 1'b0, 8'h20, 8'h10, 8'h20, 4'b0010},
        {3'd3, 1'b0, 1'b0, 8'h81, 8'h00, 8'h02, 4'b0010},
        {3'd3, 1'b0, 1'b1, 8'h40, 8'h00, 8'h81, 4'b0100},
        {3'd4, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 4'b1010},
        {3'd4, 1'b0, 1'b1, 8'h02, 8'h00, 8'h81, 4'b0100},
        {3'd5, 1'b0, 1'b1, 8'h00, 8'h55, 8'h00, 4'b1010},
        {3'd7, 1'b0, 1'b0, 8'h9C, 8'h00, 8'h9C, 4'b0100},
        {3'd6, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h7F, 4'b0010}
    };

    logic       clk;
    logic       rst_n;
    logic       valid_in;
    logic [2:0] op_sel;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic       carry_in;
    logic       dec_mode;
    logic       valid_out;
    logic [7:0] result;
    logic       flag_z;
    logic       flag_n;
    logic       flag_c;
    logic       flag_v;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit finished = 0;

    bcd_alu u_bcd_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .carry_in  (carry_in),
        .dec_mode  (dec_mode),
        .valid_out (valid_out),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_c    (flag_c),
        .flag_v    (flag_v)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1;
            failures = failures + 1;
            checks   = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic dec);
        case (op)
            3'd0:    return dec ? "R5/R6 decimal add" : "R3 binary add";
            3'd1:    return dec ? "R7 decimal subtract" : "R4 binary subtract";
            3'd2:    return "R8 compare";
            3'd3,
            3'd4:    return "R9 rotate";
            default: return "R10 pass-through";
        endcase
    endfunction

    // drive a request on the current negedge
    task automatic drive(input logic [2:0] op, input logic dec, input logic cin,
                         input logic [7:0] a, input logic [7:0] b);
        valid_in = 1'b1;
        op_sel   = op;
        dec_mode = dec;
        carry_in = cin;
        acc_in   = a;
        opnd_in  = b;
    endtask

    function automatic logic [11:0] outs();
        return {result, flag_z, flag_n, flag_c, flag_v};
    endfunction

    initial begin
        rst_n    = 1'b0;
        valid_in = 1'b0;
        op_sel   = '0;
        acc_in   = '0;
        opnd_in  = '0;
        carry_in = 1'b0;
        dec_mode = 1'b0;

        repeat (3) @(negedge clk);
        check("R1 reset outputs during reset", {3'b000, valid_out, outs()[11:4]}, 12'h000);
        check("R1 reset flags during reset", {8'h00, outs()[3:0]}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs after release", {valid_out, 3'b000, outs()[11:4]}, 12'h000);

        // table walk: strobe, then sample two edges later
        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            v = VEC[i];
            drive(v[32:30], v[29], v[28], v[27:20], v[19:12]);
            @(negedge clk);
            valid_in = 1'b0;
            acc_in   = ~acc_in;
            opnd_in  = ~opnd_in;
            if (i == 0) check("R2 no pulse one cycle after strobe", {11'h0, valid_out}, 12'h000);
            @(negedge clk);
            check("R2 pulse two cycles after strobe", {11'h0, valid_out}, 12'h001);
            check(req_of(v[32:30], v[29]), outs(), v[11:0]);
            @(negedge clk);
        end

        // R2: pulse lasts one cycle; R11: outputs hold while inputs change
        drive(3'd0, 1'b0, 1'b0, 8'h21, 8'h03);
        @(negedge clk);
        valid_in = 1'b0;
        @(negedge clk);
        check("R2 result of single strobe", outs(), {8'h24, 4'b0000});
        @(negedge clk);
        check("R2 pulse width one cycle", {11'h0, valid_out}, 12'h000);
        acc_in  = 8'hFF;
        opnd_in = 8'hFF;
        op_sel  = 3'd1;
        repeat (3) @(negedge clk);
        check("R11 outputs hold after inputs change", outs(), {8'h24, 4'b0000});

        // R2: strobe held during S_EXEC is ignored
        drive(3'd0, 1'b0, 1'b0, 8'h01, 8'h01);
        @(negedge clk);
        drive(3'd0, 1'b0, 1'b0, 8'h10, 8'h10);
        @(negedge clk);
        valid_in = 1'b0;
        check("R2 busy strobe ignored, first result kept", outs(), {8'h02, 4'b0000});
        @(negedge clk);
        check("R2 busy strobe gives no second pulse", {11'h0, valid_out}, 12'h000);
        @(negedge clk);
        check("R2 busy strobe gives no late pulse", {11'h0, valid_out}, 12'h000);
        check("R11 result unchanged after ignored strobe", outs(), {8'h02, 4'b0000});

        // R2: chain a request from S_DONE
        drive(3'd3, 1'b0, 1'b1, 8'h00, 8'h00);
        @(negedge clk);
        valid_in = 1'b0;
        @(negedge clk);
        check("R9 rotate left of zero with carry", outs(), {8'h01, 4'b0000});
        drive(3'd4, 1'b0, 1'b0, 8'h80, 8'h00);
        @(negedge clk);
        valid_in = 1'b0;
        check("R2 chained strobe clears pulse", {11'h0, valid_out}, 12'h000);
        @(negedge clk);
        check("R2 chained pulse", {11'h0, valid_out}, 12'h001);
        check("R9 chained rotate right", outs(), {8'h40, 4'b0000});

        // R7: decimal subtract with tens borrow beyond zero
        drive(3'd1, 1'b1, 1'b0, 8'h00, 8'h99);
        @(negedge clk);
        valid_in = 1'b0;
        @(negedge clk);
        check("R7 decimal 00-99-1 wraps to 00", outs(), {8'h00, 4'b0000});

        // R1: reset in the middle of operation clears outputs
        @(negedge clk);
        drive(3'd0, 1'b0, 1'b0, 8'h7F, 8'h01);
        @(negedge clk);
        valid_in = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R1 reset mid-operation", {valid_out, 3'b000, outs()[11:4]}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 no pulse after mid-operation reset", {11'h0, valid_out}, 12'h000);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule